// File: doc/BRIEF.md
# Two-Unit Non-Pipelined Execute Stage

This block is the execute stage of an in-order pipeline. It holds two execute units that do the same job at different speeds. The short unit holds an instruction for 2 cycles and the long unit holds one for 4 cycles. Decode hands over one instruction at a time. Each instruction carries a one-bit unit selector, a sequence tag, a destination register index and an operand. Each instruction goes to exactly one unit.

Neither unit is pipelined, and there is no queue in front of either one. An instruction whose unit is occupied therefore waits in decode. The block raises a decode stall for it and a matching fetch hold, so the next instruction stays in fetch. Results go to the memory/write-back side as soon as each unit finishes, each through a single registered output port. A short instruction issued after a long one can leave first. If both units finish in the same cycle, the instruction that issued earlier leaves first. The other unit keeps its result, and stays occupied, for one more cycle.

The arithmetic is a stand-in. The short unit adds one to the operand and the long unit inverts every bit of it.

Top module: `dual_exec_stage`

## Requirements
- R1: An instruction with `id_unit`=0 runs in the short unit and returns `id_operand + 1` (modulo 2^DATA_W), reported with `wb_unit`=0. An instruction with `id_unit`=1 runs in the long unit and returns the bitwise inverse of `id_operand`, reported with `wb_unit`=1. At most one unit is loaded per cycle.
- R2: When no other result is waiting, the result appears on the write-back port in the cycle after the clock edge that falls 2 edges (short) or 4 edges (long) after the issuing edge.
- R3: A unit takes no new instruction before its current result is handed out. It can take the next one on the same edge as the hand-out, so two back-to-back short instructions issue 2 edges apart.
- R4: `id_stall` is high in any cycle where `id_valid` is high and the selected unit cannot take the instruction. A stalled instruction is not consumed, and an instruction for the other, free unit is not stalled.
- R5: `fetch_hold` equals `id_stall` in every cycle.
- R6: If instructions 1, 3 and 5 use the short unit and 2 and 4 use the long unit, issued in order, they complete in the order 1, 3, 2, 5, 4. Instruction 4 waits 2 cycles in decode.
- R7: Each finished instruction raises `wb_valid` for exactly one cycle, together with its own tag, destination index and data. No `wb_valid` appears without an issued instruction.
- R8: When both units finish in the same cycle, the earlier-issued result goes out first and the other one goes out on the next cycle. Until then the later-issued result's unit counts as busy.
- R9: During and right after synchronous active-high reset, `wb_valid` is 0, both units are idle, and `id_stall` is 0 even when `id_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode offers an instruction |
| id_unit | input | 1 | Unit selector: 0 short, 1 long |
| id_tag | input | TAG_W | Sequence tag of the offered instruction |
| id_dest | input | DEST_W | Destination register index |
| id_operand | input | DATA_W | Operand value |
| id_stall | output | 1 | Offered instruction must stay in decode |
| fetch_hold | output | 1 | Fetch must hold its instruction |
| wb_valid | output | 1 | One-cycle completion strobe |
| wb_unit | output | 1 | Unit that produced the result |
| wb_tag | output | TAG_W | Tag of the completed instruction |
| wb_dest | output | DEST_W | Destination index of the completed instruction |
| wb_data | output | DATA_W | Result value |

## Verification
Some rules are checked by the assertions in every cycle. No unit is loaded while it is occupied. A unit is never ready on the cycle after it is loaded. A waiting result keeps its value. At most one unit is loaded and at most one is granted per cycle. A stall never comes with a load. Every grant turns into exactly one write-back strobe, and a same-cycle double finish resolves in one cycle. Some behaviour only the directed scenarios can show: the exact latency in cycles, the transform values, the out-of-order completion order of the five-instruction mix, the extra stall cycle that a tie costs the later-issued unit, and the timing of the stall and fetch hold relative to each issue.

// File: rtl/dx_pkg.sv
package dx_pkg;
  typedef enum logic {
    UNIT_SHORT = 1'b0,
    UNIT_LONG  = 1'b1
  } unit_e;

  typedef enum logic {
    XF_INC = 1'b0,
    XF_INV = 1'b1
  } xform_e;
endpackage

// File: rtl/dx_exec_unit.sv
module dx_exec_unit
  import dx_pkg::*;
#(
  parameter int     LAT    = 2,
  parameter int     TAG_W  = 4,
  parameter int     DEST_W = 5,
  parameter int     DATA_W = 16,
  parameter xform_e XFORM  = XF_INC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DEST_W-1:0] in_dest,
  input  logic [DATA_W-1:0] in_data,
  input  logic              grant,
  output logic              free,
  output logic              done,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DEST_W-1:0] out_dest,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] xf;

  generate
    if (XFORM == XF_INC) begin : g_inc
      assign xf = in_data + DATA_W'(1);
    end else begin : g_inv
      assign xf = ~in_data;
    end
  endgenerate

  assign done = active && (cnt == '0);
  assign free = !active || (done && grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      out_tag  <= '0;
      out_dest <= '0;
      out_data <= '0;
    end else if (load) begin
      active   <= 1'b1;
      cnt      <= CNT_W'(LAT - 1);
      out_tag  <= in_tag;
      out_dest <= in_dest;
      out_data <= xf;
    end else if (done && grant) begin
      active <= 1'b0;
    end else if (active && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: never loaded while occupied
  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> free) else $error("unit loaded while busy");

  // R2: at least two cycles of occupancy
  assert_no_early_done_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !done) else $error("unit ready one cycle after load");

  // R8: a result that is not granted waits unchanged
  assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !grant) |=> (done && $stable(out_data) && $stable(out_tag) && $stable(out_dest)))
    else $error("waiting result changed");
endmodule

// File: rtl/dx_issue_gate.sv
module dx_issue_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       id_valid,
  input  logic       id_unit,
  input  logic [1:0] free,
  output logic [1:0] load,
  output logic       id_stall,
  output logic       fetch_hold
);
  logic sel_free;

  assign sel_free   = id_unit ? free[1] : free[0];
  assign id_stall   = id_valid && !sel_free;
  assign fetch_hold = id_stall;
  assign load[0]    = id_valid && sel_free && !id_unit;
  assign load[1]    = id_valid && sel_free && id_unit;

  // R1: one unit per instruction
  assert_one_load_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load)) else $error("both units loaded");

  // R4: a stalled instruction is not consumed
  assert_stall_no_load_R4: assert property (@(posedge clk) disable iff (rst)
    id_stall |-> (load == 2'b00)) else $error("load during stall");
endmodule

// File: rtl/dx_wb_arbiter.sv
module dx_wb_arbiter #(
  parameter int TAG_W  = 4,
  parameter int DEST_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             issue,
  input  logic [1:0]             done,
  input  logic [1:0][TAG_W-1:0]  tag,
  input  logic [1:0][DEST_W-1:0] dest,
  input  logic [1:0][DATA_W-1:0] data,
  output logic [1:0]             grant,
  output logic                   wb_valid,
  output logic                   wb_unit,
  output logic [TAG_W-1:0]       wb_tag,
  output logic [DEST_W-1:0]      wb_dest,
  output logic [DATA_W-1:0]      wb_data
);
  // set when the long unit received the most recent instruction
  logic long_younger;

  assign grant[0] = done[0] && (!done[1] || long_younger);
  assign grant[1] = done[1] && (!done[0] || !long_younger);

  always_ff @(posedge clk) begin
    if (rst) begin
      long_younger <= 1'b0;
    end else if (issue[1]) begin
      long_younger <= 1'b1;
    end else if (issue[0]) begin
      long_younger <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_unit  <= 1'b0;
      wb_tag   <= '0;
      wb_dest  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= |grant;
      if (grant[1]) begin
        wb_unit <= 1'b1;
        wb_tag  <= tag[1];
        wb_dest <= dest[1];
        wb_data <= data[1];
      end else if (grant[0]) begin
        wb_unit <= 1'b0;
        wb_tag  <= tag[0];
        wb_dest <= dest[0];
        wb_data <= data[0];
      end
    end
  end

  // R8: single write port, one grant at a time
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)) else $error("two grants");

  // R8: a tie is resolved by the next cycle
  assert_tie_resolves_R8: assert property (@(posedge clk) disable iff (rst)
    (done == 2'b11) |=> (done[0] != done[1])) else $error("tie not resolved");

  // R7: every grant gives one strobe, and no strobe without a grant
  assert_grant_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (grant != 2'b00) |=> wb_valid) else $error("grant without strobe");
  assert_no_stray_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (grant == 2'b00) |=> !wb_valid) else $error("strobe without grant");
endmodule

// File: rtl/dual_exec_stage.sv
module dual_exec_stage
  import dx_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int DEST_W    = 5,
  parameter int DATA_W    = 16,
  parameter int SHORT_LAT = 2,
  parameter int LONG_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic              id_unit,
  input  logic [TAG_W-1:0]  id_tag,
  input  logic [DEST_W-1:0] id_dest,
  input  logic [DATA_W-1:0] id_operand,
  output logic              id_stall,
  output logic              fetch_hold,
  output logic              wb_valid,
  output logic              wb_unit,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DEST_W-1:0] wb_dest,
  output logic [DATA_W-1:0] wb_data
);
  localparam int NUM_UNITS = 2;

  logic [NUM_UNITS-1:0]             load, free, done, grant;
  logic [NUM_UNITS-1:0][TAG_W-1:0]  u_tag;
  logic [NUM_UNITS-1:0][DEST_W-1:0] u_dest;
  logic [NUM_UNITS-1:0][DATA_W-1:0] u_data;

  dx_issue_gate i_gate (
    .clk        (clk),
    .rst        (rst),
    .id_valid   (id_valid),
    .id_unit    (id_unit),
    .free       (free),
    .load       (load),
    .id_stall   (id_stall),
    .fetch_hold (fetch_hold)
  );

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int     U_LAT = (u == 0) ? SHORT_LAT : LONG_LAT;
      localparam xform_e U_XF  = (u == 0) ? XF_INC : XF_INV;
      dx_exec_unit #(
        .LAT    (U_LAT),
        .TAG_W  (TAG_W),
        .DEST_W (DEST_W),
        .DATA_W (DATA_W),
        .XFORM  (U_XF)
      ) i_unit (
        .clk      (clk),
        .rst      (rst),
        .load     (load[u]),
        .in_tag   (id_tag),
        .in_dest  (id_dest),
        .in_data  (id_operand),
        .grant    (grant[u]),
        .free     (free[u]),
        .done     (done[u]),
        .out_tag  (u_tag[u]),
        .out_dest (u_dest[u]),
        .out_data (u_data[u])
      );
    end
  endgenerate

  dx_wb_arbiter #(
    .TAG_W  (TAG_W),
    .DEST_W (DEST_W),
    .DATA_W (DATA_W)
  ) i_arb (
    .clk      (clk),
    .rst      (rst),
    .issue    (load),
    .done     (done),
    .tag      (u_tag),
    .dest     (u_dest),
    .data     (u_data),
    .grant    (grant),
    .wb_valid (wb_valid),
    .wb_unit  (wb_unit),
    .wb_tag   (wb_tag),
    .wb_dest  (wb_dest),
    .wb_data  (wb_data)
  );

  // R4: an occupied, unfinished long unit always stalls a long instruction
  assert_long_busy_stalls_R4: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_unit && !free[1]) |-> id_stall) else $error("missing stall");
endmodule

// File: tb/test_dual_exec_stage.sv
`timescale 1ns/1ps
module test_dual_exec_stage;
  localparam int TAG_W = 4, DEST_W = 5, DATA_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic id_valid = 1'b0, id_unit = 1'b0;
  logic [TAG_W-1:0]  id_tag = '0;
  logic [DEST_W-1:0] id_dest = '0;
  logic [DATA_W-1:0] id_operand = '0;
  logic id_stall, fetch_hold, wb_valid, wb_unit;
  logic [TAG_W-1:0]  wb_tag;
  logic [DEST_W-1:0] wb_dest;
  logic [DATA_W-1:0] wb_data;

  dual_exec_stage i_dual_exec_stage (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n_wb = 0;
  int log_tag [64], log_dest [64], log_data [64], log_unit [64], log_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wb_valid && n_wb < 64) begin
      log_tag[n_wb]  = int'(wb_tag);
      log_dest[n_wb] = int'(wb_dest);
      log_data[n_wb] = int'(wb_data);
      log_unit[n_wb] = int'(wb_unit);
      log_cyc[n_wb]  = cyc;
      n_wb = n_wb + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // starts and ends at a falling edge; returns issuing edge and stall count
  task automatic issue(input logic unit, input int tag, input int dest, input int op,
                       output int edge_n, output int stalls);
    id_valid = 1'b1; id_unit = unit;
    id_tag = TAG_W'(tag); id_dest = DEST_W'(dest); id_operand = DATA_W'(op);
    stalls = 0;
    forever begin
      #1;
      chk("R5", "fetch_hold vs id_stall", int'(fetch_hold), int'(id_stall));
      if (!id_stall) break;
      stalls++;
      @(negedge clk);
    end
    edge_n = cyc + 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    id_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; id_valid = 1'b1; id_unit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "wb_valid in reset", int'(wb_valid), 0);
    chk("R9", "id_stall in reset", int'(id_stall), 0);
    id_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "wb_valid after reset", int'(wb_valid), 0);
    id_valid = 1'b1; #1;
    chk("R9", "units idle after reset", int'(id_stall), 0);
    id_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single;
    int e1, e2, s;
    n_wb = 0;
    issue(1'b0, 1, 7, 16'h1234, e1, s);
    idle(8);
    issue(1'b1, 2, 9, 16'h00FF, e2, s);
    idle(8);
    chk("R7", "single count", n_wb, 2);
    chk("R1", "short data", log_data[0], 16'h1235);
    chk("R1", "short unit", log_unit[0], 0);
    chk("R7", "short tag/dest", log_tag[0] * 100 + log_dest[0], 107);
    chk("R2", "short latency", log_cyc[0] - e1, 2);
    chk("R1", "long data", log_data[1], 16'hFF00);
    chk("R1", "long unit", log_unit[1], 1);
    chk("R7", "long tag/dest", log_tag[1] * 100 + log_dest[1], 209);
    chk("R2", "long latency", log_cyc[1] - e2, 4);
    n_wb = 0;
    issue(1'b0, 3, 1, 16'hFFFF, e1, s);
    idle(6);
    chk("R1", "short wrap data", log_data[0], 0);
  endtask

  task automatic t_back_to_back;
    int ea, eb, sa, sb, el, es, sl, ss;
    n_wb = 0;
    issue(1'b0, 4, 2, 10, ea, sa);
    issue(1'b0, 5, 3, 20, eb, sb);
    idle(8);
    chk("R4", "second short stalls", sb, 1);
    chk("R3", "issue spacing", eb - ea, 2);
    chk("R3", "second wb timing", log_cyc[1] - ea, 4);
    chk("R1", "second data", log_data[1], 21);
    n_wb = 0;
    issue(1'b1, 6, 4, 1, el, sl);
    issue(1'b0, 7, 5, 2, es, ss);
    idle(8);
    chk("R4", "other unit not stalled", ss, 0);
    chk("R4", "consecutive issue", es - el, 1);
  endtask

  task automatic t_sequence;
    int e [6], s [6];
    n_wb = 0;
    for (int i = 1; i <= 5; i++) begin
      issue((i % 2 == 0) ? 1'b1 : 1'b0, i, i, 100 + i, e[i], s[i]);
    end
    idle(10);
    chk("R6", "sequence count", n_wb, 5);
    chk("R6", "order 1st", log_tag[0], 1);
    chk("R6", "order 2nd", log_tag[1], 3);
    chk("R6", "order 3rd", log_tag[2], 2);
    chk("R6", "order 4th", log_tag[3], 5);
    chk("R6", "order 5th", log_tag[4], 4);
    chk("R6", "instr 4 decode wait", s[4], 2);
    chk("R6", "instr 3 no wait", s[3], 0);
  endtask

  task automatic t_tie;
    int el, es, e2, s, ss, s2;
    n_wb = 0;
    issue(1'b1, 8, 10, 16'h0F0F, el, s);
    idle(1);
    issue(1'b0, 9, 11, 30, es, ss);
    issue(1'b0, 10, 12, 40, e2, s2);
    idle(8);
    chk("R8", "tie count", n_wb, 3);
    chk("R8", "older first", log_tag[0], 8);
    chk("R8", "younger second", log_tag[1], 9);
    chk("R8", "older at latency", log_cyc[0] - el, 4);
    chk("R8", "younger one cycle later", log_cyc[1] - log_cyc[0], 1);
    chk("R8", "busy while waiting", s2, 2);
    chk("R8", "third result", log_tag[2], 10);
  endtask

  task automatic t_quiet;
    n_wb = 0;
    idle(12);
    chk("R7", "no strobe when idle", n_wb, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_single;
    t_back_to_back;
    t_sequence;
    t_tie;
    t_quiet;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule